// File: doc/BRIEF.md
# Parallel ADC Conversion-and-Read Controller

This block drives an external sampling converter that delivers its result over a byte-wide parallel bus. When the host raises a start request while the controller is idle, the controller pulls the active-low convert-start line low for a set number of clock cycles. It then waits for the end of the conversion. The end is either the converter's busy flag seen low once a blanking delay has passed, or a fixed conversion timeout. After that the controller issues two read strobes, with chip-select and read asserted together for each.

The first strobe captures the upper eight result bits. The second strobe captures a byte whose two top bits are the two least significant result bits. The controller assembles a 10-bit word, waits out a recovery interval so that the next convert-start falls well after the last strobe edge, and then presents the word with a one-cycle valid pulse while it returns to ready. Every interval is a parameter in system clock cycles. Each parameter is rounded up from the converter's minimum time at the chosen clock rate.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, convst_n_o, cs_n_o and rd_n_o are high, ready_o is high and valid_o is low.
- R2: A start_i sampled high at a clock edge while ready_o is high drives convst_n_o low from that edge for exactly CONV_CYC cycles. convst_n_o never falls otherwise.
- R3: While waiting, busy_i is ignored for the first BUSY_DLY_CYC wait cycles. After that, the cycle after busy_i is sampled low is the first read cycle. If busy never rises, the first read cycle comes BUSY_DLY_CYC+1 cycles after convst_n_o rises.
- R4: If busy_i stays high, the first read cycle comes exactly TMO_CYC cycles after convst_n_o rises.
- R5: There are two read strobes. In each, cs_n_o and rd_n_o are low together for RD_CYC cycles. The strobes are separated by GAP_CYC cycles with both lines high. convst_n_o is high whenever rd_n_o is low.
- R6: db_i is captured on the edge that ends each strobe. result_o = {first byte[7:0], second byte[7:6]}, and result_o changes only in a cycle where valid_o is high.
- R7: valid_o is a one-cycle pulse. It comes REC_CYC cycles after the second strobe ends, so the next convst_n_o fall is at least REC_CYC+1 cycles after the last rd_n_o rise.
- R8: ready_o is low from the cycle after a start is accepted until the valid_o cycle, in which it is high again.
- R9: A start_i received while ready_o is low is ignored, and the operation in progress yields exactly one convert-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken only when ready |
| ready_o | output | 1 | High when idle and able to accept a start |
| convst_n_o | output | 1 | Active-low convert-start to the converter |
| busy_i | input | 1 | Converter busy flag |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| db_i | input | 8 | Converter data bus |
| result_o | output | 10 | Assembled conversion result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Conversions are run with four busy shapes: a long busy pulse that ends the wait, a busy pulse that falls inside the blanking delay, a busy flag that never rises, and a busy flag stuck high. These separate the busy-driven exit from the timeout exit and expose sampling busy too early. Byte pairs with distinct upper and lower patterns (including lower bytes with only bit 7 or bit 6 set, and junk in the low six bits) show the order of the two reads and where the LSBs are taken from. A start held high shows the recovery spacing between back-to-back conversions. Start pulses during conversion and during reads show that requests are ignored while busy.

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int CONV_CYC     = 3,
  parameter int BUSY_DLY_CYC = 4,
  parameter int TMO_CYC      = 288,
  parameter int RD_CYC       = 2,
  parameter int GAP_CYC      = 2,
  parameter int REC_CYC      = 7,
  parameter bit USE_BUSY     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       ready_o,
  output logic       convst_n_o,
  input  logic       busy_i,
  output logic       cs_n_o,
  output logic       rd_n_o,
  input  logic [7:0] db_i,
  output logic [9:0] result_o,
  output logic       valid_o
);
  localparam int M1 = (CONV_CYC > TMO_CYC) ? CONV_CYC : TMO_CYC;
  localparam int M2 = (RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC;
  localparam int M3 = (REC_CYC > BUSY_DLY_CYC) ? REC_CYC : BUSY_DLY_CYC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M4 > M3) ? M4 : M3;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_WAIT, S_RDH, S_GAP, S_RDL, S_REC} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [7:0]  hi_q;
  logic [1:0]  lo_q;
  int          lim;
  logic        last, wait_done, strobe;

  always_comb begin
    case (st)
      S_CONV:  lim = CONV_CYC;
      S_WAIT:  lim = TMO_CYC;
      S_RDH,
      S_RDL:   lim = RD_CYC;
      S_GAP:   lim = GAP_CYC;
      S_REC:   lim = REC_CYC;
      default: lim = 1;
    endcase
  end

  assign last      = (cnt == CW'(lim - 1));
  assign wait_done = last || (USE_BUSY && (cnt >= CW'(BUSY_DLY_CYC)) && !busy_i);
  assign strobe    = (st == S_RDH) || (st == S_RDL);
  assign cs_n_o    = !strobe;
  assign rd_n_o    = !strobe;
  assign convst_n_o = (st != S_CONV);
  assign ready_o   = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      cnt     <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_i) st <= S_CONV;
        end
        S_CONV: if (last) begin st <= S_WAIT; cnt <= '0; end
        S_WAIT: if (wait_done) begin st <= S_RDH; cnt <= '0; end
        S_RDH: if (last) begin hi_q <= db_i; st <= S_GAP; cnt <= '0; end
        S_GAP: if (last) begin st <= S_RDL; cnt <= '0; end
        S_RDL: if (last) begin lo_q <= db_i[7:6]; st <= S_REC; cnt <= '0; end
        S_REC: if (last) begin
          st       <= S_IDLE;
          cnt      <= '0;
          result_o <= {hi_q, lo_q};
          valid_o  <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_conv_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> $past(ready_o && start_i));
  p_early_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cnt < CW'(BUSY_DLY_CYC) && !last) |=> (st == S_WAIT));
  p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cnt == CW'(TMO_CYC - 1)) |=> !rd_n_o);
  p_no_conv_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> convst_n_o);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> valid_o);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_valid_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ready_o);
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && start_i && convst_n_o) |=> convst_n_o);
endmodule

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;
  localparam int C = 3, BD = 4, TMO = 288, R = 2, G = 2, RC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_i = 1'b0;
  logic [7:0] db_i;
  logic ready_o, convst_n_o, cs_n_o, rd_n_o, valid_o;
  logic [9:0] result_o;

  always #4 clk = ~clk;

  adc_rd_ctrl #(.CONV_CYC(C), .BUSY_DLY_CYC(BD), .TMO_CYC(TMO), .RD_CYC(R),
                .GAP_CYC(G), .REC_CYC(RC), .USE_BUSY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
    .convst_n_o(convst_n_o), .busy_i(busy_i), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .db_i(db_i), .result_o(result_o), .valid_o(valid_o));

  int checks = 0, fails = 0;
  bit done = 0;

  // converter stand-in
  logic [7:0] hi_b = 8'h00, lo_b = 8'h00;
  int brise = -1, blen = 0, since = 0;
  bit cprev = 1, rprev = 1, second = 0;
  int ncyc = 0, t_rise = 0, t_rdfall = 0, conv_falls = 0;
  assign db_i = second ? lo_b : hi_b;

  always @(negedge clk) begin
    ncyc++;
    if (!convst_n_o && cprev) begin since = 0; conv_falls++; end else since++;
    if (convst_n_o && !cprev) t_rise = ncyc;
    if (!rd_n_o && rprev && !second) t_rdfall = ncyc;
    if (rd_n_o && !rprev) second = 1;
    if (!convst_n_o) second = 0;
    cprev = convst_n_o;
    rprev = rd_n_o;
    busy_i <= (brise >= 0 && since >= brise && since < brise + blen);
  end

  // reference model
  bit m_act = 0, m_valid = 0;
  int t = 0, wend = -1;
  logic [9:0] m_res = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_valid = 0; m_res = '0;
    end else begin
      bit was;
      was = m_act;
      m_valid = 0;
      if (m_act) begin
        if (wend < 0 && t >= C && ((t - C) == TMO - 1 || ((t - C) >= BD && !busy_i)))
          wend = t + 1;
        t++;
        if (wend >= 0 && t == wend + 2*R + G + RC) begin
          m_act = 0; m_valid = 1; m_res = {hi_b, lo_b[7:6]};
        end
      end
      if (!was && start_i) begin m_act = 1; t = 0; wend = -1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit e_conv, e_strb;
    e_conv = m_act && t < C;
    e_strb = m_act && wend >= 0 &&
             ((t >= wend && t < wend + R) || (t >= wend + R + G && t < wend + 2*R + G));
    chk(convst_n_o == !e_conv, "R2 convst_n", convst_n_o, !e_conv);
    chk(rd_n_o == !e_strb && cs_n_o == !e_strb, "R5 strobes", {cs_n_o, rd_n_o}, {!e_strb, !e_strb});
    chk(ready_o == !m_act, "R8 ready", ready_o, !m_act);
    chk(valid_o == m_valid, "R7 valid", valid_o, m_valid);
    if (m_valid) chk(result_o == m_res, "R6 result", result_o, m_res);
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic conv(input logic [7:0] h, input logic [7:0] l, input int br, input int bl);
    hi_b = h; lo_b = l; brise = br; blen = bl;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!valid_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(convst_n_o && cs_n_o && rd_n_o && ready_o && !valid_o, "R1 reset",
        {convst_n_o, cs_n_o, rd_n_o, ready_o, valid_o}, 5'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(convst_n_o && cs_n_o && rd_n_o && ready_o && !valid_o, "R1 after reset",
        {convst_n_o, cs_n_o, rd_n_o, ready_o, valid_o}, 5'b11110);

    conv(8'hA5, 8'hC0, 1, 20);
    conv(8'h3C, 8'h80, 1, 2);
    // R3: busy never rises, read after the blanking delay
    conv(8'hFF, 8'h7F, -1, 0);
    chk(t_rdfall - t_rise == BD + 1, "R3 wait length", t_rdfall - t_rise, BD + 1);
    // R4: busy stuck high, timeout
    conv(8'h01, 8'h40, 1, 100000);
    chk(t_rdfall - t_rise == TMO, "R4 timeout length", t_rdfall - t_rise, TMO);
    chk(result_o == 10'h005, "R6 lsb placement", result_o, 10'h005);

    // R9: starts during conversion and reads are ignored
    conv_falls = 0;
    hi_b = 8'h5A; lo_b = 8'hBF; brise = 1; blen = 6;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (rd_n_o) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (!valid_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(conv_falls == 1, "R9 single convert", conv_falls, 1);

    // R7: start held high, back-to-back with recovery gap
    conv_falls = 0;
    hi_b = 8'h96; lo_b = 8'h40; brise = 0; blen = 8;
    @(negedge clk); start_i = 1'b1;
    while (conv_falls < 3) @(negedge clk);
    start_i = 1'b0;
    while (!valid_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(conv_falls == 3, "R7 back-to-back count", conv_falls, 3);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule